// File: doc/BRIEF.md
# Region-Steered Level-One Data Cache

This block sits between a processor's load/store unit and a simple line-wide memory port. It sorts every data address by memory region and sends it to one of three storage arrays: a small stack array for addresses inside the configured stack window, a small static-data array for addresses inside the configured global-data window, and a larger general array for everything else. This includes heap, read-only data and any address that matches no window. Only the chosen array gets an enable for the length of that access. The two unused arrays keep their contents and stay quiet, which is where the power saving comes from.

Each array is direct-mapped, write-back and write-allocate, with 16-byte lines and a valid and a dirty bit per line. A miss holds back the response. If the victim line is dirty it is first written back over the shared memory port, and then the missing line is refilled. Region windows are loaded through a small configuration port. Per-array access and hit counters show where requests went.

Top module: `rsc_dcache`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. For each accepted request, `rsp_valid` pulses for exactly one cycle. A load's `rsp_rdata` then holds the 32-bit word at the request address as the processor last wrote it, or the memory word if it was never written.
- R2: Window registers are written with `cfg_sel` 0 for the stack low limit (inclusive), 1 for the stack base (exclusive), 2 for the static low bound (inclusive) and 3 for the static high bound (exclusive). An address with limit <= addr < base goes to the stack array. Otherwise, an address with low <= addr < high goes to the static array. Everything else goes to the general array, including every address while the windows are still at their reset value of 0.
- R3: For the duration of an access, exactly one of `en_stk`, `en_sta` and `en_main` is 1, and it is the one for the region chosen in R2. A single access never has two enables at the same time.
- R4: While the block is idle (`req_ready` = 1), all three enables and `mem_req` are 0.
- R5: A request uses the window values as they stood when it was accepted. A configuration write in the same cycle as the acceptance affects only requests accepted in later cycles.
- R6: Each array is direct-mapped. The line index is taken from the address bits just above the 4-bit line offset, and word w of a line sits at line bits [32w+31:32w], where w = addr[3:2]. Two addresses with the same index and different tags evict each other.
- R7: A hit, whether load or store, makes no memory transfer, and a store hit marks the line dirty. A miss whose victim is dirty makes one write-back and then one refill. A miss whose victim is clean makes one refill only.
- R8: A store miss first refills the line and then merges the store into it. Byte-enable bit i selects data bits [8i+7:8i], and bytes that are not enabled keep their old value.
- R9: The memory port carries one transfer at a time. `mem_req` stays at 1 with `mem_addr` and `mem_we` stable until `mem_ack`. A write-back uses `mem_we` = 1 and puts the victim line at the victim's own address. A refill uses `mem_we` = 0.
- R10: Each array's access counter rises by one per request steered to it. Its hit counter rises only when the first lookup of that request hits. Both counters read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Window register select (see R2) |
| cfg_wdata | input | ADDR_W | Window register value |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Load data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wline | output | LINE_BYTES*8 | Write-back line data |
| mem_ack | input | 1 | Transfer done, one-cycle pulse |
| mem_rline | input | LINE_BYTES*8 | Refill line data, valid with `mem_ack` |
| en_stk | output | 1 | Stack array enable |
| en_sta | output | 1 | Static array enable |
| en_main | output | 1 | General array enable |
| stk_acc | output | CNT_W | Stack array access count |
| stk_hit | output | CNT_W | Stack array hit count |
| sta_acc | output | CNT_W | Static array access count |
| sta_hit | output | CNT_W | Static array hit count |
| main_acc | output | CNT_W | General array access count |
| main_hit | output | CNT_W | General array hit count |

## Verification
A window-register write and the classification of a new request can fall in the same clock edge. The bench provokes this by driving a stack-limit change and a load just below the old limit in the same cycle. It expects the general array's enable for that load, and the stack array's enable for the same load issued again a cycle later. The other overlap is a write-back followed straight away by a refill on the shared port. This case is set up by evicting a dirty stack line, and it is judged by the transfer counts, by the written-back word held in the memory model, and by the reloaded data.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int N_ARR = 3;

  // array index doubles as region code
  typedef enum logic [1:0] {
    RG_STACK  = 2'd0,
    RG_STATIC = 2'd1,
    RG_MAIN   = 2'd2
  } region_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_RESP
  } fsm_e;

  typedef enum logic [1:0] {
    CFG_STK_LIMIT = 2'd0,
    CFG_STK_BASE  = 2'd1,
    CFG_STA_LO    = 2'd2,
    CFG_STA_HI    = 2'd3
  } cfg_sel_e;

  function automatic int lines_of(input int g, input int stk, input int sta, input int gen);
    if (g == 0) return stk;
    if (g == 1) return sta;
    return gen;
  endfunction

endpackage

// File: rtl/rsc_region_map.sv
module rsc_region_map
  import rsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  logic [ADDR_W-1:0] stk_limit_q, stk_base_q, sta_lo_q, sta_hi_q;

  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] lo,
                                  input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_limit_q <= '0;
      stk_base_q  <= '0;
      sta_lo_q    <= '0;
      sta_hi_q    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_STK_LIMIT: stk_limit_q <= cfg_wdata;
        CFG_STK_BASE:  stk_base_q  <= cfg_wdata;
        CFG_STA_LO:    sta_lo_q    <= cfg_wdata;
        default:       sta_hi_q    <= cfg_wdata;
      endcase
    end
  end

  // stack window wins over static window if they overlap
  always_comb begin
    if (in_win(addr, stk_limit_q, stk_base_q))   region = RG_STACK;
    else if (in_win(addr, sta_lo_q, sta_hi_q))   region = RG_STATIC;
    else                                         region = RG_MAIN;
  end

endmodule

// File: rtl/rsc_cachelet.sv
module rsc_cachelet #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [DATA_W/8-1:0]     be,
  input  logic                    fill_en,
  input  logic [LINE_BYTES*8-1:0] fill_line,
  output logic                    hit,
  output logic [DATA_W-1:0]       rdata,
  output logic                    vic_dirty,
  output logic [ADDR_W-1:0]       vic_addr,
  output logic [LINE_BYTES*8-1:0] vic_line
);

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int BPW    = DATA_W / 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BOFF_W = $clog2(BPW);
  localparam int WSEL_W = OFF_W - BOFF_W;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINE_W-1:0] dat_q [LINES];
  logic [LINES-1:0]  val_q, dty_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tg;
  logic [WSEL_W-1:0] wsel;
  logic [LINE_W-1:0] cur_line, merged_line;
  logic              tag_eq;
  logic              unused_lo;

  assign idx       = addr[OFF_W +: IDX_W];
  assign tg        = addr[ADDR_W-1 -: TAG_W];
  assign wsel      = addr[BOFF_W +: WSEL_W];
  assign unused_lo = ^addr[BOFF_W-1:0];

  assign cur_line  = dat_q[idx];
  assign tag_eq    = (tag_q[idx] == tg);
  assign hit       = en && val_q[idx] && tag_eq;
  assign rdata     = cur_line[int'(wsel)*DATA_W +: DATA_W];
  assign vic_dirty = val_q[idx] && dty_q[idx];
  assign vic_addr  = {tag_q[idx], idx, {OFF_W{1'b0}}};
  assign vic_line  = cur_line;

  // byte merge of a store into the addressed word
  always_comb begin
    merged_line = cur_line;
    for (int b = 0; b < BPW; b++) begin
      if (be[b]) merged_line[int'(wsel)*DATA_W + b*8 +: 8] = wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dty_q <= '0;
    end else if (en) begin
      if (fill_en) begin
        val_q[idx] <= 1'b1;
        dty_q[idx] <= 1'b0;
      end else if (wr_en && hit) begin
        dty_q[idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      if (fill_en) begin
        tag_q[idx] <= tg;
        dat_q[idx] <= fill_line;
      end else if (wr_en && hit) begin
        dat_q[idx] <= merged_line;
      end
    end
  end

endmodule

// File: rtl/rsc_dcache.sv
module rsc_dcache
  import rsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int STK_LINES  = 4,
  parameter int STA_LINES  = 4,
  parameter int MAIN_LINES = 8,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [ADDR_W-1:0]       cfg_wdata,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W/8-1:0]     req_be,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wline,
  input  logic                    mem_ack,
  input  logic [LINE_BYTES*8-1:0] mem_rline,
  output logic                    en_stk,
  output logic                    en_sta,
  output logic                    en_main,
  output logic [CNT_W-1:0]        stk_acc,
  output logic [CNT_W-1:0]        stk_hit,
  output logic [CNT_W-1:0]        sta_acc,
  output logic [CNT_W-1:0]        sta_hit,
  output logic [CNT_W-1:0]        main_acc,
  output logic [CNT_W-1:0]        main_hit
);

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int BPW    = DATA_W / 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);

  fsm_e              state_q;
  region_e           rq_reg_q, new_reg;
  logic [ADDR_W-1:0] rq_addr_q;
  logic              rq_we_q;
  logic [DATA_W-1:0] rq_wdata_q, rsp_data_q;
  logic [BPW-1:0]    rq_be_q;
  logic              first_q;

  logic [N_ARR-1:0]  en_v, hit_v, vic_dirty_v;
  logic [DATA_W-1:0] rdata_v    [N_ARR];
  logic [ADDR_W-1:0] vic_addr_v [N_ARR];
  logic [LINE_W-1:0] vic_line_v [N_ARR];
  logic [CNT_W-1:0]  acc_q      [N_ARR];
  logic [CNT_W-1:0]  hitc_q     [N_ARR];

  logic              sel_hit, sel_vic_dirty;
  logic [DATA_W-1:0] sel_rdata;
  logic [ADDR_W-1:0] sel_vic_addr;
  logic [LINE_W-1:0] sel_vic_line;

  // named internal events
  logic accept, busy, lookup_hit, lookup_miss, wb_done, fill_done, wr_en;

  assign accept      = req_valid && (state_q == ST_IDLE);
  assign busy        = (state_q == ST_LOOKUP) || (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign lookup_hit  = (state_q == ST_LOOKUP) && sel_hit;
  assign lookup_miss = (state_q == ST_LOOKUP) && !sel_hit;
  assign wb_done     = (state_q == ST_WBACK) && mem_ack;
  assign fill_done   = (state_q == ST_FILL) && mem_ack;
  assign wr_en       = (state_q == ST_LOOKUP) && rq_we_q;

  rsc_region_map #(.ADDR_W(ADDR_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .addr      (req_addr),
    .region    (new_reg)
  );

  for (genvar g = 0; g < N_ARR; g++) begin : g_arr
    localparam int LN = lines_of(g, STK_LINES, STA_LINES, MAIN_LINES);

    assign en_v[g] = busy && (rq_reg_q == region_e'(2'(g)));

    rsc_cachelet #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .LINE_BYTES (LINE_BYTES),
      .LINES      (LN)
    ) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_v[g]),
      .addr      (rq_addr_q),
      .wr_en     (wr_en),
      .wdata     (rq_wdata_q),
      .be        (rq_be_q),
      .fill_en   (fill_done),
      .fill_line (mem_rline),
      .hit       (hit_v[g]),
      .rdata     (rdata_v[g]),
      .vic_dirty (vic_dirty_v[g]),
      .vic_addr  (vic_addr_v[g]),
      .vic_line  (vic_line_v[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[g]  <= '0;
        hitc_q[g] <= '0;
      end else if ((state_q == ST_LOOKUP) && first_q && en_v[g]) begin
        acc_q[g] <= acc_q[g] + CNT_W'(1);
        if (hit_v[g]) hitc_q[g] <= hitc_q[g] + CNT_W'(1);
      end
    end
  end

  // pick the outputs of the active array
  always_comb begin
    sel_hit       = 1'b0;
    sel_vic_dirty = 1'b0;
    sel_rdata     = '0;
    sel_vic_addr  = '0;
    sel_vic_line  = '0;
    for (int g = 0; g < N_ARR; g++) begin
      if (rq_reg_q == region_e'(2'(g))) begin
        sel_hit       = hit_v[g];
        sel_vic_dirty = vic_dirty_v[g];
        sel_rdata     = rdata_v[g];
        sel_vic_addr  = vic_addr_v[g];
        sel_vic_line  = vic_line_v[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rq_reg_q   <= RG_MAIN;
      rq_addr_q  <= '0;
      rq_we_q    <= 1'b0;
      rq_wdata_q <= '0;
      rq_be_q    <= '0;
      first_q    <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          rq_reg_q   <= new_reg;
          rq_addr_q  <= req_addr;
          rq_we_q    <= req_we;
          rq_wdata_q <= req_wdata;
          rq_be_q    <= req_be;
          first_q    <= 1'b1;
          state_q    <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          first_q <= 1'b0;
          if (lookup_hit) begin
            rsp_data_q <= sel_rdata;
            state_q    <= ST_RESP;
          end else if (lookup_miss) begin
            state_q <= sel_vic_dirty ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: if (wb_done)   state_q <= ST_FILL;
        ST_FILL:  if (fill_done) state_q <= ST_LOOKUP;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rsp_data_q;

  assign mem_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = (state_q == ST_WBACK) ? sel_vic_addr
                                           : {rq_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wline = sel_vic_line;

  assign en_stk   = en_v[0];
  assign en_sta   = en_v[1];
  assign en_main  = en_v[2];
  assign stk_acc  = acc_q[0];
  assign stk_hit  = hitc_q[0];
  assign sta_acc  = acc_q[1];
  assign sta_hit  = hitc_q[1];
  assign main_acc = acc_q[2];
  assign main_hit = hitc_q[2];

endmodule

// File: rtl/rsc_dcache_chk.sv
module rsc_dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              en_stk,
  input logic              en_sta,
  input logic              en_main,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  stk_acc,
  input logic [CNT_W-1:0]  stk_hit,
  input logic [CNT_W-1:0]  sta_acc,
  input logic [CNT_W-1:0]  sta_hit,
  input logic [CNT_W-1:0]  main_acc,
  input logic [CNT_W-1:0]  main_hit
);

  logic [2:0] en_all;
  assign en_all = {en_main, en_sta, en_stk};

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_all)); // R3

  AST_EN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all != 3'b000) |=> ((en_all == 3'b000) || $stable(en_all))); // R3

  AST_RSP_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(en_all) != 3'b000)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((en_all == 3'b000) && !mem_req)); // R4

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R1

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

  AST_HIT_LE_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_hit <= stk_acc) && (sta_hit <= sta_acc) && (main_hit <= main_acc)); // R10

endmodule

bind rsc_dcache rsc_dcache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .en_stk    (en_stk),
  .en_sta    (en_sta),
  .en_main   (en_main),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .stk_acc   (stk_acc),
  .stk_hit   (stk_hit),
  .sta_acc   (sta_acc),
  .sta_hit   (sta_hit),
  .main_acc  (main_acc),
  .main_hit  (main_hit)
);

// File: tb/rsc_dcache_tb_top.sv
module rsc_dcache_tb_top;

  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int LW  = 128;
  localparam int CW  = 16;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [3:0]    req_be = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_wline;
  logic          mem_ack = 1'b0;
  logic [LW-1:0] mem_rline = '0;
  logic          en_stk, en_sta, en_main;
  logic [CW-1:0] stk_acc, stk_hit, sta_acc, sta_hit, main_acc, main_hit;

  rsc_dcache dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wline(mem_wline), .mem_ack(mem_ack), .mem_rline(mem_rline),
    .en_stk(en_stk), .en_sta(en_sta), .en_main(en_main),
    .stk_acc(stk_acc), .stk_hit(stk_hit), .sta_acc(sta_acc),
    .sta_hit(sta_hit), .main_acc(main_acc), .main_hit(main_hit)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int n_fill = 0, n_wb = 0;
  int cyc = 0, lat_cnt = 0;
  bit done = 1'b0;
  int exp_acc [3];
  int exp_hit [3];
  logic [31:0] mem_w [int unsigned];
  logic [31:0] sh_w  [int unsigned];

  function automatic logic [31:0] init_word(input int unsigned wa);
    return {wa[15:0], ~wa[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [31:0] rd_mem(input int unsigned wa);
    return mem_w.exists(wa) ? mem_w[wa] : init_word(wa);
  endfunction

  function automatic logic [31:0] rd_sh(input int unsigned wa);
    return sh_w.exists(wa) ? sh_w[wa] : init_word(wa);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // fixed-latency line memory
  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_req) begin
      if (lat_cnt == LAT - 1) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          for (int w = 0; w < 4; w++) mem_w[(mem_addr >> 2) + w] = mem_wline[32*w +: 32];
          n_wb++;
        end else begin
          for (int w = 0; w < 4; w++) mem_rline[32*w +: 32] <= rd_mem((mem_addr >> 2) + w);
          n_fill++;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      report();
      $finish;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one access; region index 0 stack, 1 static, 2 general
  task automatic access(input string rq, input bit we, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] be, input int rg,
                        input int x_fill, input int x_wb,
                        input bit cfg_go = 1'b0, input logic [1:0] cs = '0,
                        input logic [31:0] cd = '0);
    int f0 = n_fill, w0 = n_wb;
    logic [2:0] seen = '0;
    logic [31:0] exp_d;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    cfg_we = cfg_go; cfg_sel = cs; cfg_wdata = cd;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    while (!rsp_valid) begin
      seen |= {en_main, en_sta, en_stk};
      @(negedge clk);
    end
    if (we) begin
      exp_d = rd_sh(a >> 2);
      for (int b = 0; b < 4; b++) if (be[b]) exp_d[8*b +: 8] = d[8*b +: 8];
      sh_w[a >> 2] = exp_d;
    end else begin
      check(rsp_rdata == rd_sh(a >> 2), rq, $sformatf("load data @%0h", a),
            rsp_rdata, rd_sh(a >> 2));
    end
    check(seen == (3'b001 << rg), rq, "enable set (R3)", 32'(seen), 32'(3'b001 << rg));
    check((n_fill - f0) == x_fill, "R7", "refill count", n_fill - f0, x_fill);
    check((n_wb - w0) == x_wb, "R7", "write-back count", n_wb - w0, x_wb);
    exp_acc[rg]++;
    if (x_fill == 0) exp_hit[rg]++;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1", "rsp after reset", 32'(rsp_valid), 0);
    check({en_main, en_sta, en_stk} == 3'b000, "R4", "enables idle",
          32'({en_main, en_sta, en_stk}), 0);
    check(mem_req == 1'b0, "R4", "mem idle", 32'(mem_req), 0);
    check((stk_acc | sta_acc | main_acc | stk_hit | sta_hit | main_hit) == '0,
          "R10", "counters zero", 32'(stk_acc | sta_acc | main_acc), 0);
  endtask

  task automatic t_classify();
    access("R2", 1'b0, 32'h7000_0010, '0, '0, 2, 1, 0);   // unconfigured -> general
    cfg_write(2'd0, 32'h7000_0000);
    cfg_write(2'd1, 32'h7000_1000);
    cfg_write(2'd2, 32'h1000_0000);
    cfg_write(2'd3, 32'h1000_1000);
    access("R2", 1'b0, 32'h7000_0000, '0, '0, 0, 1, 0);   // stack low limit
    access("R2", 1'b0, 32'h7000_0FFC, '0, '0, 0, 1, 0);   // just below base
    access("R2", 1'b0, 32'h7000_1000, '0, '0, 2, 1, 0);   // base excluded
    access("R2", 1'b0, 32'h1000_0000, '0, '0, 1, 1, 0);   // static low
    access("R2", 1'b0, 32'h1000_0FFC, '0, '0, 1, 1, 0);
    access("R2", 1'b0, 32'h1000_1000, '0, '0, 2, 1, 0);   // static high excluded
    access("R2", 1'b0, 32'h2000_0040, '0, '0, 2, 1, 0);   // heap
    access("R2", 1'b0, 32'h0040_0000, '0, '0, 2, 1, 0);   // read-only data
  endtask

  task automatic t_hit_and_store();
    access("R10", 1'b0, 32'h7000_0020, '0, '0, 0, 1, 0);
    access("R10", 1'b0, 32'h7000_0020, '0, '0, 0, 0, 0);  // hit
    access("R7", 1'b1, 32'h7000_0024, 32'h1234_5678, 4'hF, 0, 0, 0);
    access("R1", 1'b0, 32'h7000_0024, '0, '0, 0, 0, 0);
  endtask

  task automatic t_evict();
    access("R8", 1'b1, 32'h7000_0000, 32'hCAFE_F00D, 4'b0011, 0, 0, 0);
    access("R6", 1'b0, 32'h7000_0040, '0, '0, 0, 1, 1);   // same index, dirty victim
    check(rd_mem(32'h7000_0000 >> 2) == rd_sh(32'h7000_0000 >> 2), "R9",
          "written-back word", rd_mem(32'h7000_0000 >> 2), rd_sh(32'h7000_0000 >> 2));
    access("R6", 1'b0, 32'h7000_0000, '0, '0, 0, 1, 0);   // clean victim
  endtask

  task automatic t_store_miss();
    access("R8", 1'b1, 32'h1000_0084, 32'hDEAD_BEEF, 4'b0100, 1, 1, 0);
    access("R8", 1'b0, 32'h1000_0084, '0, '0, 1, 0, 0);
  endtask

  task automatic t_cfg_same_cycle();
    access("R5", 1'b0, 32'h6FFF_FFF0, '0, '0, 2, 1, 0, 1'b1, 2'd0, 32'h6FFF_F000);
    access("R5", 1'b0, 32'h6FFF_FFF0, '0, '0, 0, 1, 0);
  endtask

  task automatic t_counters();
    @(negedge clk);
    check(stk_acc  == CW'(exp_acc[0]), "R10", "stack accesses",   32'(stk_acc),  exp_acc[0]);
    check(stk_hit  == CW'(exp_hit[0]), "R10", "stack hits",       32'(stk_hit),  exp_hit[0]);
    check(sta_acc  == CW'(exp_acc[1]), "R10", "static accesses",  32'(sta_acc),  exp_acc[1]);
    check(sta_hit  == CW'(exp_hit[1]), "R10", "static hits",      32'(sta_hit),  exp_hit[1]);
    check(main_acc == CW'(exp_acc[2]), "R10", "general accesses", 32'(main_acc), exp_acc[2]);
    check(main_hit == CW'(exp_hit[2]), "R10", "general hits",     32'(main_hit), exp_hit[2]);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      exp_acc[i] = 0;
      exp_hit[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_classify();
    t_hit_and_store();
    t_evict();
    t_store_miss();
    t_cfg_same_cycle();
    t_counters();
    done = 1'b1;
    report();
    $finish;
  end

endmodule